// File: doc/BRIEF.md
# Pin Multiplexing Crossbar

This block is a register-programmed crossbar. It sits between the internal signals of a chip and its external pads. There are two kinds of internal signals: GPIO port bits and peripheral signals, such as a serial transmitter and receiver. Routing runs in both directions through independent selector registers:

- **Pad direction.** Every pad has a source selector. It names the internal driver whose level and output enable reach the pad.
- **Internal direction.** Every internal input has its own pad selector. It names the pad that feeds the input. A single pad may feed several internal inputs at once.
- **Pad control.** Every pad also has a control register. It holds an input enable, which gates whether internal logic sees the pad level, and pull-up and pull-down requests that are brought out to the pad ring.

Software programs the crossbar through a plain write strobe with a combinational read-back port. Once a register is written, routing is purely combinational from that register. No data is buffered, so no handshake is involved: internal signals and pads are level signals that pass straight through the selected paths.

A pad can be driven by a GPIO bit and routed back into that same GPIO's input. The driven level can then be read back.

Top module: `pinmux_xbar`

## Requirements
- R1: After reset every selector and control register reads 0. In that state:
  - `pad_out`, `pad_oe`, `pad_pu` and `pad_pd` are all 0.
  - `gpio_in` and `periph_in` are all 0, whatever the pad levels are.
- R2: The register map uses byte addresses, read and written as 16-bit words.
  - Pad p has its source selector at 8*p and its control register at 8*p+4.
  - GPIO input bit b of port n has its pad selector at 0x100 + 64*n + 4*b.
  - Peripheral input k has its pad selector at 0x200 + 4*k.
  - A register reads back the written value truncated to its field width: 6 bits for source selectors, 4 bits for pad selectors and 3 bits for control.
  - Addresses outside the map read 0, and writes to them change no register.
- R3: Source selector codes are:
  - 0 means no source.
  - 1 + 16*n + b selects GPIO port n bit b (codes 1 to 32).
  - 33 + k selects peripheral output k (codes 33 and 34).
- R4: A pad whose selector names a GPIO bit outputs that bit's level on `pad_out` and takes that bit's output enable on `pad_oe`.
- R5: A pad whose selector names a peripheral output outputs that peripheral's level, with `pad_oe` held at 1.
- R6: A pad whose selector is 0 or an unused code (35 to 63) has `pad_out` = 0 and `pad_oe` = 0.
- R7: In pad selectors, code p+1 names pad p (codes 1 to 8). An internal input whose selector names pad p carries `pad_in[p]` while that pad's input enable is set.
- R8: An internal input carries 0 in either of these cases:
  - its selector is 0 or an unused code (9 to 15);
  - the named pad's input enable is clear.
- R9: Several internal inputs (GPIO and peripheral) that name the same pad all carry that pad's level at the same time.
- R10: A pad driven by GPIO bit g and selected by g's input returns the driven level to `gpio_in[g]` while the pad is driven, and returns the external level when it is not.
- R11: The control register fields are:
  - bit 0: input enable;
  - bit 1: pull-up request, shown on `pad_pu`;
  - bit 2: pull-down request, shown on `pad_pd`.

  The other bits read 0.
- R12: A write changes the routing from the clock edge that samples it. Before that edge, the outputs keep their previous routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 10 | Byte address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| gpio_out | input | 32 | GPIO output levels, bit 16*n+b for port n bit b |
| gpio_oe | input | 32 | GPIO output enables, same indexing |
| gpio_in | output | 32 | Levels routed to GPIO inputs |
| periph_out | input | 2 | Peripheral output levels |
| periph_in | output | 2 | Levels routed to peripheral inputs |
| pad_in | input | 8 | Levels seen at the pads |
| pad_out | output | 8 | Levels driven toward the pads |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up requests |
| pad_pd | output | 8 | Pad pull-down requests |

## Verification
The hardest situation to bring about is the loopback case, where a pad's input level depends on the block's own pad output. The bench reaches it by modelling each pad as resolving to the driven level when `pad_oe` is high and to an external level otherwise. It then routes a GPIO bit both to a pad and back from that pad, toggling the GPIO and the external level in opposite directions.

The bench also sweeps every pad against every 6-bit source code, and every internal input against every 4-bit pad code. The sweeps run with input enables both set and clear, so the unused codes and the gating paths are all exercised.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // Register map layout (byte addresses)
  localparam int unsigned PAD_REG_STRIDE    = 8;
  localparam int unsigned PAD_CTL_OFS       = 4;
  localparam int unsigned GPIO_SEL_BASE     = 'h100;
  localparam int unsigned GPIO_PORT_STRIDE  = 64;
  localparam int unsigned GPIO_BIT_STRIDE   = 4;
  localparam int unsigned PERIPH_SEL_BASE   = 'h200;
  localparam int unsigned PERIPH_SEL_STRIDE = 4;

  // Width of the pad control field
  localparam int unsigned PAD_CTL_W = 3;

  // Pad control field: bit0 input enable, bit1 pull-up, bit2 pull-down
  typedef struct packed {
    logic pull_dn;
    logic pull_up;
    logic in_en;
  } pad_ctl_t;

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PADS  = 8,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_BITS = 16,
  parameter int unsigned NUM_PIN   = 2,
  parameter int unsigned SRC_W     = 6,
  parameter int unsigned PAD_W     = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [NUM_PADS-1:0][SRC_W-1:0]      pad_sel_o,
  output pad_ctl_t [NUM_PADS-1:0]             pad_ctl_o,
  output logic [NUM_PORTS*PORT_BITS-1:0][PAD_W-1:0] gpio_sel_o,
  output logic [NUM_PIN-1:0][PAD_W-1:0]       pin_sel_o
);

  localparam int unsigned NUM_GPIO = NUM_PORTS * PORT_BITS;

  logic [NUM_PADS-1:0][SRC_W-1:0]  pad_sel_q;
  pad_ctl_t [NUM_PADS-1:0]         pad_ctl_q;
  logic [NUM_GPIO-1:0][PAD_W-1:0]  gpio_sel_q;
  logic [NUM_PIN-1:0][PAD_W-1:0]   pin_sel_q;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i;

  function automatic logic [ADDR_W-1:0] pad_sel_addr(input int unsigned p);
    return ADDR_W'(p * PAD_REG_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] pad_ctl_addr(input int unsigned p);
    return ADDR_W'(p * PAD_REG_STRIDE + PAD_CTL_OFS);
  endfunction

  function automatic logic [ADDR_W-1:0] gpio_sel_addr(input int unsigned g);
    return ADDR_W'(GPIO_SEL_BASE + (g / PORT_BITS) * GPIO_PORT_STRIDE
                   + (g % PORT_BITS) * GPIO_BIT_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] pin_sel_addr(input int unsigned k);
    return ADDR_W'(PERIPH_SEL_BASE + k * PERIPH_SEL_STRIDE);
  endfunction

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_sel_q  <= '0;
      pad_ctl_q  <= '0;
      gpio_sel_q <= '0;
      pin_sel_q  <= '0;
    end else if (wr_en_i) begin
      for (int unsigned p = 0; p < NUM_PADS; p++) begin
        if (addr_i == pad_sel_addr(p)) pad_sel_q[p] <= wdata_i[SRC_W-1:0];
        if (addr_i == pad_ctl_addr(p)) pad_ctl_q[p] <= pad_ctl_t'(wdata_i[PAD_CTL_W-1:0]);
      end
      for (int unsigned g = 0; g < NUM_GPIO; g++) begin
        if (addr_i == gpio_sel_addr(g)) gpio_sel_q[g] <= wdata_i[PAD_W-1:0];
      end
      for (int unsigned k = 0; k < NUM_PIN; k++) begin
        if (addr_i == pin_sel_addr(k)) pin_sel_q[k] <= wdata_i[PAD_W-1:0];
      end
    end
  end

  // Combinational read-back; unmapped addresses return zero
  always_comb begin
    rdata_o = '0;
    for (int unsigned p = 0; p < NUM_PADS; p++) begin
      if (addr_i == pad_sel_addr(p)) rdata_o = DATA_W'(pad_sel_q[p]);
      if (addr_i == pad_ctl_addr(p)) rdata_o = DATA_W'(pad_ctl_q[p]);
    end
    for (int unsigned g = 0; g < NUM_GPIO; g++) begin
      if (addr_i == gpio_sel_addr(g)) rdata_o = DATA_W'(gpio_sel_q[g]);
    end
    for (int unsigned k = 0; k < NUM_PIN; k++) begin
      if (addr_i == pin_sel_addr(k)) rdata_o = DATA_W'(pin_sel_q[k]);
    end
  end

  assign pad_sel_o  = pad_sel_q;
  assign pad_ctl_o  = pad_ctl_q;
  assign gpio_sel_o = gpio_sel_q;
  assign pin_sel_o  = pin_sel_q;

  // R2: a write to a pad selector lands in that pad's register
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
    a_r2_pad_sel_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == pad_sel_addr(p)) |=> (pad_sel_q[p] == $past(wdata_i[SRC_W-1:0])));
  end

  // R2: a write to a GPIO input selector lands in that input's register
  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio_chk
    a_r2_gpio_sel_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == gpio_sel_addr(g)) |=> (gpio_sel_q[g] == $past(wdata_i[PAD_W-1:0])));
  end

  // R12: without a write strobe no routing register moves
  a_r12_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(pad_sel_q) && $stable(pad_ctl_q)
                  && $stable(gpio_sel_q) && $stable(pin_sel_q)));

endmodule

// File: rtl/pinmux_pad_drive.sv
module pinmux_pad_drive #(
  parameter int unsigned NUM_GPIO = 32,
  parameter int unsigned NUM_POUT = 2,
  parameter int unsigned SRC_W    = 6
) (
  input  logic [SRC_W-1:0]    sel_i,
  input  logic [NUM_GPIO-1:0] gpio_out_i,
  input  logic [NUM_GPIO-1:0] gpio_oe_i,
  input  logic [NUM_POUT-1:0] periph_out_i,
  output logic                out_o,
  output logic                oe_o
);

  // Code 0 is no source; GPIO codes follow, then peripheral outputs
  localparam int unsigned GPIO_CODE0 = 1;
  localparam int unsigned POUT_CODE0 = GPIO_CODE0 + NUM_GPIO;

  always_comb begin
    out_o = 1'b0;
    oe_o  = 1'b0;
    for (int unsigned k = 0; k < NUM_GPIO; k++) begin
      if (sel_i == SRC_W'(GPIO_CODE0 + k)) begin
        out_o = gpio_out_i[k];
        oe_o  = gpio_oe_i[k];
      end
    end
    for (int unsigned k = 0; k < NUM_POUT; k++) begin
      if (sel_i == SRC_W'(POUT_CODE0 + k)) begin
        out_o = periph_out_i[k];
        oe_o  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pinmux_sink_route.sv
module pinmux_sink_route #(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned PAD_W    = 4
) (
  input  logic [PAD_W-1:0]    sel_i,
  input  logic [NUM_PADS-1:0] pad_in_i,
  input  logic [NUM_PADS-1:0] pad_ie_i,
  output logic                val_o
);

  // Code p+1 names pad p; any other code yields 0
  always_comb begin
    val_o = 1'b0;
    for (int unsigned p = 0; p < NUM_PADS; p++) begin
      if (sel_i == PAD_W'(p + 1)) val_o = pad_in_i[p] & pad_ie_i[p];
    end
  end

endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PADS  = 8,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_BITS = 16,
  parameter int unsigned NUM_POUT  = 2,
  parameter int unsigned NUM_PIN   = 2,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr_en,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [DATA_W-1:0]               reg_rdata,
  input  logic [NUM_PORTS*PORT_BITS-1:0]  gpio_out,
  input  logic [NUM_PORTS*PORT_BITS-1:0]  gpio_oe,
  output logic [NUM_PORTS*PORT_BITS-1:0]  gpio_in,
  input  logic [NUM_POUT-1:0]             periph_out,
  output logic [NUM_PIN-1:0]              periph_in,
  input  logic [NUM_PADS-1:0]             pad_in,
  output logic [NUM_PADS-1:0]             pad_out,
  output logic [NUM_PADS-1:0]             pad_oe,
  output logic [NUM_PADS-1:0]             pad_pu,
  output logic [NUM_PADS-1:0]             pad_pd
);

  localparam int unsigned NUM_GPIO = NUM_PORTS * PORT_BITS;
  localparam int unsigned NUM_SRC  = 1 + NUM_GPIO + NUM_POUT;
  localparam int unsigned SRC_W    = $clog2(NUM_SRC);
  localparam int unsigned PAD_W    = $clog2(NUM_PADS + 1);

  logic [NUM_PADS-1:0][SRC_W-1:0] pad_sel;
  pad_ctl_t [NUM_PADS-1:0]        pad_ctl;
  logic [NUM_GPIO-1:0][PAD_W-1:0] gpio_sel;
  logic [NUM_PIN-1:0][PAD_W-1:0]  pin_sel;
  logic [NUM_PADS-1:0]            pad_ie;

  pinmux_regs #(
    .NUM_PADS (NUM_PADS),
    .NUM_PORTS(NUM_PORTS),
    .PORT_BITS(PORT_BITS),
    .NUM_PIN  (NUM_PIN),
    .SRC_W    (SRC_W),
    .PAD_W    (PAD_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_en),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .rdata_o   (reg_rdata),
    .pad_sel_o (pad_sel),
    .pad_ctl_o (pad_ctl),
    .gpio_sel_o(gpio_sel),
    .pin_sel_o (pin_sel)
  );

  // Pad side: one driver mux and control decode per pad
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pinmux_pad_drive #(
      .NUM_GPIO(NUM_GPIO),
      .NUM_POUT(NUM_POUT),
      .SRC_W   (SRC_W)
    ) i_drive (
      .sel_i       (pad_sel[p]),
      .gpio_out_i  (gpio_out),
      .gpio_oe_i   (gpio_oe),
      .periph_out_i(periph_out),
      .out_o       (pad_out[p]),
      .oe_o        (pad_oe[p])
    );
    assign pad_ie[p] = pad_ctl[p].in_en;
    assign pad_pu[p] = pad_ctl[p].pull_up;
    assign pad_pd[p] = pad_ctl[p].pull_dn;

    // R6: an unselected pad is neither enabled nor driven high
    a_r6_unsel_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (pad_sel[p] == '0) |-> (!pad_oe[p] && !pad_out[p]));
    // R5: a peripheral source always enables the pad
    a_r5_periph_drives : assert property (@(posedge clk) disable iff (!rst_n)
      (pad_sel[p] > SRC_W'(NUM_GPIO) && pad_sel[p] < SRC_W'(NUM_SRC)) |-> pad_oe[p]);
  end

  // Internal side: GPIO inputs
  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio_sink
    pinmux_sink_route #(
      .NUM_PADS(NUM_PADS),
      .PAD_W   (PAD_W)
    ) i_route (
      .sel_i   (gpio_sel[g]),
      .pad_in_i(pad_in),
      .pad_ie_i(pad_ie),
      .val_o   (gpio_in[g])
    );

    // R8: an unrouted GPIO input reads 0
    a_r8_unrouted_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (gpio_sel[g] == '0) |-> !gpio_in[g]);
  end

  // Internal side: peripheral inputs
  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin_sink
    pinmux_sink_route #(
      .NUM_PADS(NUM_PADS),
      .PAD_W   (PAD_W)
    ) i_route (
      .sel_i   (pin_sel[k]),
      .pad_in_i(pad_in),
      .pad_ie_i(pad_ie),
      .val_o   (periph_in[k])
    );

    // R8: no peripheral input sees a level while every input enable is clear
    a_r8_ie_gate : assert property (@(posedge clk) disable iff (!rst_n)
      (pad_ie == '0) |-> !periph_in[k]);
  end

endmodule

// File: tb/test_pinmux_xbar.sv
module test_pinmux_xbar;

  localparam int NP = 8;
  localparam int NG = 32;
  localparam int NPO = 2;
  localparam int NPI = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NG-1:0] gpio_out = '0, gpio_oe = '0, gpio_in;
  logic [NPO-1:0] periph_out = '0;
  logic [NPI-1:0] periph_in;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic [NP-1:0] ext_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Pad model: driven level wins over the external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  pinmux_xbar i_pinmux_xbar (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .gpio_in(gpio_in), .periph_out(periph_out),
    .periph_in(periph_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 10'(a); reg_wdata = 16'(d); reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = 10'(a);
    #1 d = reg_rdata;
  endtask

  function automatic int gpio_addr(input int g);
    return 'h100 + 64 * (g / 16) + 4 * (g % 16);
  endfunction

  function automatic int sink_addr(input int s);
    return (s < NG) ? gpio_addr(s) : 'h200 + 4 * (s - NG);
  endfunction

  function automatic logic [1:0] exp_pad(input int code);
    if (code >= 1 && code <= NG) return {gpio_oe[code-1], gpio_out[code-1]};
    if (code > NG && code <= NG + NPO) return {1'b1, periph_out[code-1-NG]};
    return 2'b00;
  endfunction

  function automatic logic sink_val(input int s);
    return (s < NG) ? gpio_in[s] : periph_in[s-NG];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    ext_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset outputs
    check("R1 pad_out", 32'(pad_out), 0);
    check("R1 pad_oe", 32'(pad_oe), 0);
    check("R1 pulls", 32'({pad_pu, pad_pd}), 0);
    check("R1 gpio_in", gpio_in, 0);
    check("R1 periph_in", 32'(periph_in), 0);

    // R2 unmapped writes touch nothing: 0x040 (pad 8), 0x180 (port 2), 0x208, 0x3FE
    wr('h040, 'hFFFF); wr('h180, 'hFFFF); wr('h208, 'hFFFF); wr('h3FE, 'hFFFF);
    for (int p = 0; p < NP; p++) begin
      rd(8 * p, d);     check("R1 R2 pad sel", 32'(d), 0);
      rd(8 * p + 4, d); check("R1 R2 pad ctl", 32'(d), 0);
    end
    for (int s = 0; s < NG + NPI; s++) begin
      rd(sink_addr(s), d); check("R1 R2 sink sel", 32'(d), 0);
    end
    rd('h180, d); check("R2 unmapped read", 32'(d), 0);
    check("R2 unmapped no oe", 32'(pad_oe), 0);

    // R2 truncation
    wr(0, 'hFFFF); rd(0, d); check("R2 src sel width", 32'(d), 'h3F);
    wr(gpio_addr(17), 'hFFFF); rd(gpio_addr(17), d); check("R2 pad sel width", 32'(d), 'hF);
    wr('h204, 'h1235); rd('h204, d); check("R2 periph sel width", 32'(d), 'h5);
    wr(0, 0); wr(gpio_addr(17), 0); wr('h204, 0);

    // R11 control fields
    for (int v = 0; v < 8; v++) begin
      wr(8 * 3 + 4, v | 'hFFF8);
      rd(8 * 3 + 4, d);
      check("R11 ctl readback", 32'(d), 32'(v));
      check("R11 pull pins", 32'({pad_pu[3], pad_pd[3]}), 32'({v[1], v[2]}));
    end
    wr(8 * 3 + 4, 0);

    // R3 R4 R5 R6: every pad against every source code
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 64; c++) begin
        wr(8 * p, c);
        for (int pat = 0; pat < 2; pat++) begin
          gpio_out   = pat ? 32'h5A3C_F096 : 32'hA5C3_0F69;
          gpio_oe    = pat ? 32'hC30F_65AA : 32'h3CF0_9A55;
          periph_out = pat ? 2'b10 : 2'b01;
          #1;
          check("R3 R4 R5 R6 pad drive", 32'({pad_oe[p], pad_out[p]}), 32'(exp_pad(c)));
        end
      end
      wr(8 * p, 0);
    end
    gpio_oe = '0;

    // R12: routing changes only at the sampling edge
    gpio_out = '1; gpio_oe = '1;
    @(negedge clk);
    reg_addr = 10'(8 * 1); reg_wdata = 16'd5; reg_wr_en = 1'b1;
    #1 check("R12 before edge", 32'(pad_oe[1]), 0);
    @(negedge clk); reg_wr_en = 1'b0;
    #1 check("R12 after edge", 32'(pad_oe[1]), 1);
    wr(8 * 1, 0); gpio_oe = '0; gpio_out = '0;

    // R7 R8: every sink against every pad code, input enable clear then set
    for (int ie = 0; ie < 2; ie++) begin
      for (int p = 0; p < NP; p++) wr(8 * p + 4, ie);
      for (int s = 0; s < NG + NPI; s++) begin
        for (int c = 0; c < 16; c++) begin
          wr(sink_addr(s), c);
          for (int pat = 0; pat < 2; pat++) begin
            ext_in = pat ? 8'hA5 : 8'h5A;
            #1;
            check("R7 R8 sink route", 32'(sink_val(s)),
                  (c >= 1 && c <= NP && ie == 1) ? 32'(ext_in[c-1]) : 0);
          end
        end
        wr(sink_addr(s), 0);
      end
    end

    // R9: one pad feeds two GPIO inputs and a peripheral input
    wr(gpio_addr(0), 5); wr(gpio_addr(21), 5); wr('h204, 5);
    for (int v = 0; v < 2; v++) begin
      ext_in = v ? 8'h10 : 8'hEF;
      #1 check("R9 fan-out", 32'({gpio_in[0], gpio_in[21], periph_in[1]}), v ? 7 : 0);
    end
    wr(gpio_addr(0), 0); wr(gpio_addr(21), 0); wr('h204, 0);

    // R10: loopback of GPIO 7 through pad 2
    wr(8 * 2, 8); wr(gpio_addr(7), 3);
    gpio_oe[7] = 1'b1;
    for (int v = 0; v < 2; v++) begin
      gpio_out[7] = v[0]; ext_in[2] = ~v[0];
      #1 check("R10 read back driven", 32'(gpio_in[7]), 32'(v));
    end
    gpio_oe[7] = 1'b0; ext_in[2] = 1'b1; gpio_out[7] = 1'b0;
    #1 check("R10 undriven reads external", 32'(gpio_in[7]), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule